// File: doc/BRIEF.md
# UART Byte FIFO Pair with Trigger Interrupts

This block holds the transmit and receive byte queues of one serial channel. The host pushes bytes for transmission and the serializer drains them. The deserializer pushes received bytes and the host drains them. A write-only control byte turns the queues on, clears either queue on demand and picks a trigger level for each direction. The block raises two interrupt lines: a receive-data request when enough bytes are waiting, and a transmit-ready request under a low-water rule. The low-water rule remembers whether the host's last reload filled the queue past the trigger level.

With the queues turned off, each direction becomes a single-byte holding register, and both interrupts follow the presence of that one byte. Baud timing, the shift registers and interrupt prioritization live elsewhere.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both overrun flags are 0, irq_tx is 1, irq_rx is 0, cfg_legacy is 0, the queues are off (one-byte mode) and both trigger codes are 00.
- R2: A control write with bit 0 set turns the queues on and stores bit 3 (shown on cfg_legacy), bits [5:4] (transmit code) and bits [7:6] (receive code). A control write with bit 0 clear turns the queues off and leaves bit 3 and both codes unchanged.
- R3: A control write that changes the on/off state empties both queues and clears both overrun flags, visible on the cycle after the write.
- R4: A control write with bits 0 and 1 set empties the receive queue, and one with bits 0 and 2 set empties the transmit queue. Each clear zeroes that queue's level and overrun flag, leaves the other queue and both data outputs untouched, and is not stored: a later write without the bit clears nothing.
- R5: With the queues on, each queue holds 32 bytes and returns them in push order. A pop strobe puts the byte on the data output on the following cycle. The level outputs show the occupancy.
- R6: A push into a full queue is dropped and sets that queue's overrun flag. The flag stays set until reset or a clear of that queue (R3, R4). A push and a pop on a full queue in the same cycle still drop the push.
- R7: A pop from an empty queue changes neither the level nor the data output.
- R8: With the queues off, each queue holds one byte.
- R9: irq_rx is 1 while the queues are on and the receive level is at least 8, 16, 24 or 28 for receive codes 00, 01, 10, 11. While they are off, it is 1 exactly when the receive byte is present. It follows the level on the same cycle.
- R10: A host push that leaves the transmit level above the transmit trigger (8, 16, 24, 30 for codes 00..11) while the queues are on marks the queue as reloaded. When marked, irq_tx sets as the level drops below the trigger, and the mark clears. When not marked, irq_tx sets only when the level reaches 0.
- R11: Once set, irq_tx stays 1 until a host push is accepted, which clears it. Reset, a transmit clear and an on/off change set irq_tx and clear the reload mark.
- R12: Bit 3 of the control byte has no effect on levels, data or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| host_tx_push | input | 1 | Host writes a byte to the transmit queue |
| host_tx_data | input | 8 | Byte to transmit |
| ser_tx_pop | input | 1 | Serializer takes a byte |
| ser_tx_data | output | 8 | Byte taken by the last accepted serializer pop |
| ser_rx_push | input | 1 | Deserializer delivers a byte |
| ser_rx_data | input | 8 | Received byte |
| host_rx_pop | input | 1 | Host reads a byte |
| host_rx_data | output | 8 | Byte read by the last accepted host pop |
| tx_level | output | 6 | Transmit occupancy |
| rx_level | output | 6 | Receive occupancy |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_overrun | output | 1 | Sticky receive overrun |
| irq_tx | output | 1 | Transmit-ready request |
| irq_rx | output | 1 | Receive-data request |
| cfg_legacy | output | 1 | Stored legacy mode bit |

## Verification
The bench aims at the transmit reload mark. It fills past the trigger and drains, and separately refills to below the trigger and drains. A design that ignored the mark would raise irq_tx at the wrong level in one of the two cases. It also writes control bytes with bit 0 clear but other bits set, which a design without write gating would turn into clears or code changes. It drives simultaneous push and pop on full and empty queues, where an off-by-one count or overrun rule shows up as a level mismatch. Queue clears are checked to leave the other queue, the data outputs and later writes unaffected.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Control byte field positions (decoded by the control register)
  localparam int BIT_EN     = 0;
  localparam int BIT_RXCLR  = 1;
  localparam int BIT_TXCLR  = 2;
  localparam int BIT_LEGACY = 3;
  localparam int TXSEL_LSB  = 4;
  localparam int RXSEL_LSB  = 6;

  typedef struct packed {
    logic       en;
    logic       legacy;
    logic [1:0] tx_code;
    logic [1:0] rx_code;
  } fifo_cfg_t;

  function automatic int unsigned tx_trig(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 30;
    endcase
  endfunction

  function automatic int unsigned rx_trig(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       en_q,
  output logic       en_nx,
  output logic       legacy_q,
  output logic [1:0] tx_code_q,
  output logic [1:0] rx_code_nx,
  output logic       flush_tx,
  output logic       flush_rx
);

  fifo_cfg_t cfg_q;
  fifo_cfg_t cfg_d;
  logic      wr_on;

  assign wr_on = cfg_wdata[BIT_EN];

  // next-state
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      if (wr_on) begin
        cfg_d.en      = 1'b1;
        cfg_d.legacy  = cfg_wdata[BIT_LEGACY];
        cfg_d.tx_code = cfg_wdata[TXSEL_LSB +: 2];
        cfg_d.rx_code = cfg_wdata[RXSEL_LSB +: 2];
      end else begin
        cfg_d.en = 1'b0;
      end
    end
  end

  // Clear pulses: explicit clear bits only count with bit 0 set; any
  // change of the on/off state empties both queues.
  always_comb begin
    flush_tx = 1'b0;
    flush_rx = 1'b0;
    if (cfg_we) begin
      if (wr_on) begin
        flush_tx = cfg_wdata[BIT_TXCLR] | ~cfg_q.en;
        flush_rx = cfg_wdata[BIT_RXCLR] | ~cfg_q.en;
      end else begin
        flush_tx = cfg_q.en;
        flush_rx = cfg_q.en;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  assign en_q       = cfg_q.en;
  assign en_nx      = cfg_d.en;
  assign legacy_q   = cfg_q.legacy;
  assign tx_code_q  = cfg_q.tx_code;
  assign rx_code_nx = cfg_d.rx_code;

  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[BIT_EN]) |=> ($stable(cfg_q.legacy) && $stable(cfg_q.tx_code) && $stable(cfg_q.rx_code) && !cfg_q.en)); // R2

  AST_ON_WRITE_NO_STRAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_on && cfg_q.en && !cfg_wdata[BIT_TXCLR]) |-> !flush_tx); // R4

endmodule

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_nx,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, wr_inc;
  logic [AW-1:0] rd_q, rd_d, rd_inc;
  logic [CW-1:0] level_q, level_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          empty, push_ok, pop_ok;

  // pointer advance: plain wrap for a power-of-two depth, compare otherwise
  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_inc = wr_q + 1'b1;
      assign rd_inc = rd_q + 1'b1;
    end else begin : g_npow2
      assign wr_inc = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_inc = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
  endgenerate

  assign empty   = (level_q == '0);
  assign full    = single ? !empty : (level_q == CW'(DEPTH));
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  // next-state
  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    level_d = level_q;
    dout_d  = dout_q;
    if (flush) begin
      wr_d    = '0;
      rd_d    = '0;
      level_d = '0;
    end else begin
      if (push_ok) wr_d = wr_inc;
      if (pop_ok) begin
        rd_d   = rd_inc;
        dout_d = mem[rd_q];
      end
      level_d = level_q + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
      dout_q  <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      level_q <= level_d;
      if (pop_ok) dout_q <= dout_d;
    end
  end

  // storage array, no reset needed
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  assign pop_data = dout_q;
  assign level    = level_q;
  assign level_nx = level_d;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH)); // R5

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level_q)); // R6

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> ($stable(pop_data) && level_q == '0)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level_q == '0)); // R4

  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> (level_q <= CW'(1))); // R8

endmodule

// File: rtl/sfp_txirq.sv
module sfp_txirq
  import sfp_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          enabled,
  input  logic [1:0]    code,
  input  logic          push_ok,
  input  logic [CW-1:0] level_nx,
  output logic          irq
);

  logic          armed_q, armed_d;
  logic          irq_q, irq_d;
  logic [CW-1:0] trig;
  logic          fire;

  assign trig = CW'(tx_trig(code));

  // marked queue: low-water crossing; unmarked: only on empty
  assign fire = armed_q ? (level_nx < trig) : (level_nx == '0);

  // next-state
  always_comb begin
    armed_d = armed_q;
    irq_d   = irq_q;
    if (flush) begin
      armed_d = 1'b0;
      irq_d   = 1'b1;
    end else begin
      if (push_ok && enabled && (level_nx > trig)) begin
        armed_d = 1'b1;
      end else if (fire) begin
        armed_d = 1'b0;
      end
      irq_d = push_ok ? 1'b0 : (irq_q | fire);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !flush) |=> !irq_q); // R11

  AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (irq_q && !armed_q)); // R11

  AST_UNMARKED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !push_ok && !flush && level_nx == '0) |=> irq_q); // R10

  AST_NO_MARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !armed_q) |=> !armed_q); // R10

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import sfp_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          host_tx_push,
  input  logic [DW-1:0] host_tx_data,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          host_rx_pop,
  output logic [DW-1:0] host_rx_data,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          tx_overrun,
  output logic          rx_overrun,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          cfg_legacy
);

  localparam int NDIR = 2;  // 0: transmit, 1: receive

  logic          en_q, en_nx, legacy_q;
  logic [1:0]    tx_code_q, rx_code_nx;
  logic          flush_tx, flush_rx;
  logic [CW-1:0] tx_level_nx, rx_level_nx;
  logic          tx_full, rx_full;
  logic          tx_push_ok;
  logic [NDIR-1:0] push_v, full_v, flush_v, ovr_v;
  logic          irq_rx_q, irq_rx_d;

  sfp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .en_q       (en_q),
    .en_nx      (en_nx),
    .legacy_q   (legacy_q),
    .tx_code_q  (tx_code_q),
    .rx_code_nx (rx_code_nx),
    .flush_tx   (flush_tx),
    .flush_rx   (flush_rx)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_tx),
    .single    (~en_q),
    .push      (host_tx_push),
    .push_data (host_tx_data),
    .pop       (ser_tx_pop),
    .pop_data  (ser_tx_data),
    .level     (tx_level),
    .level_nx  (tx_level_nx),
    .full      (tx_full)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_rx),
    .single    (~en_q),
    .push      (ser_rx_push),
    .push_data (ser_rx_data),
    .pop       (host_rx_pop),
    .pop_data  (host_rx_data),
    .level     (rx_level),
    .level_nx  (rx_level_nx),
    .full      (rx_full)
  );

  assign tx_push_ok = host_tx_push & ~tx_full & ~flush_tx;

  sfp_txirq #(.CW(CW)) u_txirq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_tx),
    .enabled  (en_q),
    .code     (tx_code_q),
    .push_ok  (tx_push_ok),
    .level_nx (tx_level_nx),
    .irq      (irq_tx)
  );

  // sticky overrun per direction
  assign push_v  = {ser_rx_push, host_tx_push};
  assign full_v  = {rx_full, tx_full};
  assign flush_v = {flush_rx, flush_tx};

  for (genvar i = 0; i < NDIR; i++) begin : g_ovr
    logic ovr_q, ovr_d;

    always_comb begin
      ovr_d = ovr_q;
      if (flush_v[i]) begin
        ovr_d = 1'b0;
      end else if (push_v[i] && full_v[i]) begin
        ovr_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovr_q <= 1'b0;
      end else begin
        ovr_q <= ovr_d;
      end
    end

    assign ovr_v[i] = ovr_q;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !flush_v[i]) |=> ovr_q); // R6
  end

  assign tx_overrun = ovr_v[0];
  assign rx_overrun = ovr_v[1];

  // receive request, registered against the next level and next settings
  always_comb begin
    if (en_nx) begin
      irq_rx_d = (rx_level_nx >= CW'(rx_trig(rx_code_nx)));
    end else begin
      irq_rx_d = (rx_level_nx != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx_q <= 1'b0;
    end else begin
      irq_rx_q <= irq_rx_d;
    end
  end

  assign irq_rx     = irq_rx_q;
  assign cfg_legacy = legacy_q;

  AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !irq_rx); // R9

  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[BIT_EN] != en_q)) |=> (tx_level == '0 && rx_level == '0)); // R3

endmodule

// File: tb/serial_fifo_pair_test.sv
module serial_fifo_pair_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       host_tx_push;
  logic [7:0] host_tx_data;
  logic       ser_tx_pop;
  logic [7:0] ser_tx_data;
  logic       ser_rx_push;
  logic [7:0] ser_rx_data;
  logic       host_rx_pop;
  logic [7:0] host_rx_data;
  logic [5:0] tx_level, rx_level;
  logic       tx_overrun, rx_overrun, irq_tx, irq_rx, cfg_legacy;

  always #5 clk = ~clk;

  serial_fifo_pair uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_overrun(tx_overrun), .rx_overrun(rx_overrun),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .cfg_legacy(cfg_legacy)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // reference model state
  bit         m_en, m_leg, m_txo, m_rxo, m_arm, m_irqt;
  logic [1:0] m_txc, m_rxc;
  logic [7:0] m_txd, m_rxd;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  function automatic int ftx(input logic [1:0] c);
    case (c) 2'b00: return 8; 2'b01: return 16; 2'b10: return 24; default: return 30; endcase
  endfunction

  function automatic int frx(input logic [1:0] c);
    case (c) 2'b00: return 8; 2'b01: return 16; 2'b10: return 24; default: return 28; endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rxexp;
    rxexp = m_en ? int'(rxq.size() >= frx(m_rxc)) : int'(rxq.size() != 0);
    chk("R5 tx level", int'(tx_level), txq.size());
    chk("R5 rx level", int'(rx_level), rxq.size());
    chk("R5 tx data", int'(ser_tx_data), int'(m_txd));
    chk("R5 rx data", int'(host_rx_data), int'(m_rxd));
    chk("R6 tx overrun", int'(tx_overrun), int'(m_txo));
    chk("R6 rx overrun", int'(rx_overrun), int'(m_rxo));
    chk("R10 irq_tx", int'(irq_tx), int'(m_irqt));
    chk("R9 irq_rx", int'(irq_rx), rxexp);
    chk("R2 legacy", int'(cfg_legacy), int'(m_leg));
  endtask

  task automatic model(input bit we, input logic [7:0] wd, input bit tpu, input logic [7:0] td,
                       input bit tpo, input bit rpu, input logic [7:0] rd, input bit rpo);
    bit ft, fr, full, pok, fire;
    int cap, n, trig;
    ft  = we && (wd[0] ? (wd[2] || !m_en) : m_en);
    fr  = we && (wd[0] ? (wd[1] || !m_en) : m_en);
    cap = m_en ? 32 : 1;
    if (ft) begin
      txq.delete(); m_txo = 1'b0; m_arm = 1'b0; m_irqt = 1'b1;
    end else begin
      full = (txq.size() >= cap);
      pok  = tpu && !full;
      if (tpu && full) m_txo = 1'b1;
      if (tpo && txq.size() > 0) m_txd = txq.pop_front();
      if (pok) txq.push_back(td);
      n    = txq.size();
      trig = ftx(m_txc);
      fire = m_arm ? (n < trig) : (n == 0);
      if (pok && m_en && n > trig) m_arm = 1'b1;
      else if (fire) m_arm = 1'b0;
      m_irqt = pok ? 1'b0 : (m_irqt | fire);
    end
    if (fr) begin
      rxq.delete(); m_rxo = 1'b0;
    end else begin
      full = (rxq.size() >= cap);
      if (rpu && full) m_rxo = 1'b1;
      if (rpo && rxq.size() > 0) m_rxd = rxq.pop_front();
      if (rpu && !full) rxq.push_back(rd);
    end
    if (we) begin
      if (wd[0]) begin
        m_en = 1'b1; m_leg = wd[3]; m_txc = wd[5:4]; m_rxc = wd[7:6];
      end else begin
        m_en = 1'b0;
      end
    end
  endtask

  task automatic step(input bit we, input logic [7:0] wd, input bit tpu, input logic [7:0] td,
                      input bit tpo, input bit rpu, input logic [7:0] rd, input bit rpo);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd;
    host_tx_push = tpu; host_tx_data = td; ser_tx_pop = tpo;
    ser_rx_push = rpu; ser_rx_data = rd; host_rx_pop = rpo;
    @(posedge clk);
    #1;
    model(we, wd, tpu, td, tpo, rpu, rd, rpo);
    compare_all();
  endtask

  task automatic cfg(input logic [7:0] w);     step(1'b1, w, 0, 8'h0, 0, 0, 8'h0, 0); endtask
  task automatic txpush(input logic [7:0] d);  step(1'b0, 8'h0, 1, d, 0, 0, 8'h0, 0); endtask
  task automatic txpop();                      step(1'b0, 8'h0, 0, 8'h0, 1, 0, 8'h0, 0); endtask
  task automatic rxpush(input logic [7:0] d);  step(1'b0, 8'h0, 0, 8'h0, 0, 1, d, 0); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    cfg_we = 0; cfg_wdata = 0; host_tx_push = 0; host_tx_data = 0; ser_tx_pop = 0;
    ser_rx_push = 0; ser_rx_data = 0; host_rx_pop = 0;
    m_en = 0; m_leg = 0; m_txo = 0; m_rxo = 0; m_arm = 0; m_irqt = 1;
    m_txc = 0; m_rxc = 0; m_txd = 0; m_rxd = 0;
    r = $urandom(32'd24681);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq_tx", int'(irq_tx), 1);
    chk("R1 irq_rx", int'(irq_rx), 0);
    chk("R1 tx level", int'(tx_level), 0);
    chk("R1 overrun", int'(tx_overrun | rx_overrun), 0);
    compare_all();

    cfg(8'h01);
    chk("R2 legacy after on", int'(cfg_legacy), 0);
    for (int i = 0; i < 7; i++) rxpush(8'hA0 + 8'(i));
    chk("R9 below trigger 8", int'(irq_rx), 0);
    rxpush(8'hA7);
    chk("R9 at trigger 8", int'(irq_rx), 1);
    cfg(8'h41);
    chk("R9 code 01 needs 16", int'(irq_rx), 0);

    for (int i = 0; i < 33; i++) txpush(8'(i));
    chk("R6 push into full", int'(tx_overrun), 1);
    chk("R5 capacity 32", int'(tx_level), 32);
    for (int i = 0; i < 32; i++) begin
      txpop();
      chk("R5 order", int'(ser_tx_data), i);
      if (tx_level == 6'd8) chk("R10 marked at trigger", int'(irq_tx), 0);
      if (tx_level == 6'd7) chk("R10 marked below trigger", int'(irq_tx), 1);
    end
    txpop();
    chk("R7 empty pop level", int'(tx_level), 0);
    chk("R7 empty pop data", int'(ser_tx_data), 31);
    chk("R6 sticky", int'(tx_overrun), 1);

    for (int i = 0; i < 5; i++) begin
      txpush(8'h50 + 8'(i));
      chk("R11 push clears irq_tx", int'(irq_tx), 0);
    end
    for (int i = 0; i < 4; i++) txpop();
    chk("R10 unmarked not yet empty", int'(irq_tx), 0);
    txpop();
    chk("R10 unmarked at empty", int'(irq_tx), 1);

    for (int i = 0; i < 3; i++) txpush(8'h60 + 8'(i));
    cfg(8'h45);
    chk("R4 tx cleared", int'(tx_level), 0);
    chk("R4 rx untouched", int'(rx_level), 8);
    chk("R4 overrun cleared", int'(tx_overrun), 0);
    chk("R4 data kept", int'(ser_tx_data), 8'h54);
    chk("R11 clear sets irq_tx", int'(irq_tx), 1);
    txpush(8'h70); txpush(8'h71);
    cfg(8'h41);
    chk("R4 not stored", int'(tx_level), 2);

    cfg(8'h49);
    chk("R12 legacy stored", int'(cfg_legacy), 1);
    chk("R12 tx level", int'(tx_level), 2);
    chk("R12 irq_rx", int'(irq_rx), 0);

    cfg(8'h00);
    chk("R3 tx emptied", int'(tx_level), 0);
    chk("R3 rx emptied", int'(rx_level), 0);
    cfg(8'hF6);
    chk("R2 legacy kept", int'(cfg_legacy), 1);

    txpush(8'h11); txpush(8'h12);
    chk("R8 one byte", int'(tx_level), 1);
    chk("R8 overrun", int'(tx_overrun), 1);
    rxpush(8'h21);
    chk("R8 rx byte raises irq", int'(irq_rx), 1);
    txpop();
    chk("R10 holding empty", int'(irq_tx), 1);

    cfg(8'h01);
    for (int k = 0; k < 3000; k++) begin
      bit we, tpu, tpo, rpu, rpo;
      logic [7:0] wd;
      int phase;
      phase = (k / 150) % 2;
      we  = ($urandom() % 64) == 0;
      wd  = 8'($urandom());
      if (($urandom() % 16) != 0) wd[0] = 1'b1;
      tpu = ($urandom() % 8) < (phase == 0 ? 6 : 2);
      tpo = ($urandom() % 8) < (phase == 0 ? 2 : 6);
      rpu = ($urandom() % 8) < (phase == 0 ? 6 : 2);
      rpo = ($urandom() % 8) < (phase == 0 ? 2 : 6);
      step(we, wd, tpu, 8'($urandom()), tpo, rpu, 8'($urandom()), rpo);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule